// File: doc/BRIEF.md
# Teletext Page Memory Write Controller

This block sits between a teletext packet decoder and a 40-column by 25-row character display memory. Each packet arrives as a start strobe that carries its magazine, row number, page number and subcode, followed by forty character beats. The block decides whether a packet belongs to the page the viewer has selected. If it does, the block writes the packet's characters through a single write port into the display memory. The port's address is the row number times forty plus the column.

The header row is handled with two rules. The time-of-day area at its right end follows every header on air. The page-title area is refreshed only while the block is still searching for a newly selected page. When the selected page arrives, the block leaves search mode and blanks the body of the screen. Eight status characters supplied by a keypad controller are mirrored into the first eight cells of row 0 whenever they change. These writes yield to packet traffic and are held off while the decoder warns that a frame of packets is about to arrive. The block also extracts five editorial link page numbers from a dedicated link packet. The four coloured keys and the index key use these numbers.

Top module: `txt_page_writer`

## Requirements
- R1: A write from an accepted display row packet (row 1 to 24) goes to address row*40+column for all 40 columns, one cycle after each character beat.
- R2: Columns 32 to 39 of row 0 are written by every header packet (row 0), whatever its magazine and whether or not search mode is active. Columns 0 to 7 are never written by a packet.
- R3: Columns 8 to 31 of row 0 are written by a header only in search mode. With parallel transmission (serial_mode low), the header's magazine must also equal the selected magazine.
- R4: With serial transmission (serial_mode high), headers of every magazine write columns 8 to 31 while search mode is active.
- R5: A header whose magazine and page match the selection ends search mode. It also overwrites rows 1 to 24 with the space code 0x20.
- R6: With parallel transmission, a row packet is accepted only if its magazine is the selected magazine and the most recent header of that magazine matched the selection.
- R7: With serial transmission, a row packet of any magazine is accepted only if the most recent header of any magazine matched the selection.
- R8: While sub_req is high, a header matches only if its subcode also equals sel_subcode. While sub_req is low, the subcode is ignored.
- R9: A change of any of the eight status characters rewrites that character at address 0 to 7. Character i sits at stat_chars bits [7i+6:7i]. After reset, all eight are written once.
- R10: No status-character write occurs in the cycle after frame_soon is high. A packet character or erase write always wins the port over a status write.
- R11: A row-27 packet that is accepted under R6/R7 sets link k (k = 0..3 coloured keys, 4 index) at link_pages bits [11k+10:11k] to {magazine, tens, units}. These come from the low 3 bits of column 3k, the low 4 bits of column 3k+1 and the low 4 bits of column 3k+2. The packet writes nothing to the display memory.
- R12: Any change of sel_mag, sel_page, sel_subcode or sub_req re-enters search mode and withdraws acceptance until a matching header arrives.
- R13: During reset, wr_en is low and link_pages is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Start of a packet; tag fields valid |
| pkt_mag | input | 3 | Magazine of the packet |
| pkt_row | input | 5 | Row (packet) number, 0 = header |
| pkt_page | input | 8 | Page number carried by a header |
| pkt_sub | input | 13 | Subcode carried by a header |
| chr_valid | input | 1 | Character beat of the current packet |
| chr_data | input | 7 | Character code |
| sel_mag | input | 3 | Selected magazine |
| sel_page | input | 8 | Selected page number |
| sel_subcode | input | 13 | Requested subcode |
| sub_req | input | 1 | Require subcode match |
| serial_mode | input | 1 | High for serial transmission, low for parallel |
| stat_chars | input | 56 | Eight 7-bit status characters from the keypad side |
| frame_soon | input | 1 | Packet frame imminent; hold status writes |
| wr_en | output | 1 | Display memory write strobe |
| wr_addr | output | 10 | Display memory address (row*40+column) |
| wr_data | output | 7 | Display memory write data |
| link_pages | output | 55 | Five editorial link page numbers, 11 bits each |

## Verification
Each character beat produces its write on the port one cycle later. Status writes follow one cycle after the grant. The screen blanking after a matching header needs 960 free port cycles, stretched by any header beats that interleave with it. The bench therefore samples the port on the falling edge into a shadow memory. After each packet it waits 1000 idle cycles, then compares the whole shadow against a model updated from the requirements. Link fields and the status hold-off are read after the same kind of settling delay.

// File: rtl/txt_pw_pkg.sv
package txt_pw_pkg;
  localparam int COLS     = 40;
  localparam int ROWS     = 25;
  localparam int CHR_W    = 7;
  localparam int STAT_N   = 8;
  localparam int CLOCK_N  = 8;
  localparam int LINK_ROW = 27;
  localparam int LINK_N   = 5;
  localparam int NIB_W    = 4;
  localparam int MAG_W    = 3;
  localparam int ROW_W    = 5;
  localparam int PAGE_W   = 8;
  localparam int SUB_W    = 13;
  localparam int LINK_W   = MAG_W + 2 * NIB_W;
  localparam int CELLS    = COLS * ROWS;
  localparam int ADDR_W   = $clog2(CELLS);
  localparam int COL_W    = $clog2(COLS);
  localparam logic [CHR_W-1:0] SPACE = 7'h20;

  typedef enum logic [1:0] {PK_NONE, PK_HDR, PK_ROW, PK_LINK} pkt_kind_e;

  function automatic logic [ADDR_W-1:0] cell_addr(input logic [ROW_W-1:0] r,
                                                  input logic [COL_W-1:0] c);
    return ADDR_W'(int'(r) * COLS + int'(c));
  endfunction

  // time-of-day area: always refreshed
  function automatic logic hdr_col_always(input logic [COL_W-1:0] c);
    return int'(c) >= COLS - CLOCK_N;
  endfunction

  // title area: refreshed in search mode only
  function automatic logic hdr_col_search(input logic [COL_W-1:0] c);
    return int'(c) >= STAT_N && int'(c) < COLS - CLOCK_N;
  endfunction
endpackage

// File: rtl/txt_pw_accept.sv
module txt_pw_accept
  import txt_pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic [MAG_W-1:0]  pkt_mag,
  input  logic [ROW_W-1:0]  pkt_row,
  input  logic [PAGE_W-1:0] pkt_page,
  input  logic [SUB_W-1:0]  pkt_sub,
  input  logic [MAG_W-1:0]  sel_mag,
  input  logic [PAGE_W-1:0] sel_page,
  input  logic [SUB_W-1:0]  sel_subcode,
  input  logic              sub_req,
  input  logic              serial_mode,
  output logic              search,
  output logic              row_ok,
  output logic              found,
  output logic              sel_chg
);
  localparam int MAGS  = 1 << MAG_W;
  localparam int SEL_W = 1 + MAG_W + PAGE_W + SUB_W;

  logic [SEL_W-1:0] sel_q;
  logic [MAGS-1:0]  acc_mag;
  logic             acc_any;
  logic             is_hdr, match;

  assign is_hdr  = pkt_start && pkt_row == '0;
  assign match   = pkt_mag == sel_mag && pkt_page == sel_page &&
                   (!sub_req || pkt_sub == sel_subcode);
  assign sel_chg = {sub_req, sel_mag, sel_page, sel_subcode} != sel_q;
  assign found   = is_hdr && match && search && !sel_chg;
  assign row_ok  = serial_mode ? acc_any : (acc_mag[pkt_mag] && pkt_mag == sel_mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      search  <= 1'b1;
      acc_mag <= '0;
      acc_any <= 1'b0;
    end else begin
      sel_q <= {sub_req, sel_mag, sel_page, sel_subcode};
      if (sel_chg) begin
        search  <= 1'b1;
        acc_mag <= '0;
        acc_any <= 1'b0;
      end else if (is_hdr) begin
        acc_mag[pkt_mag] <= match;
        acc_any          <= match;
        if (match) search <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txt_pw_status.sv
module txt_pw_status
  import txt_pw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [STAT_N*CHR_W-1:0] stat_chars,
  input  logic                    grant,
  output logic                    req,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [CHR_W-1:0]        req_data
);
  localparam int IDX_W = $clog2(STAT_N);

  logic [STAT_N-1:0][CHR_W-1:0] shadow;
  logic [STAT_N-1:0]            synced, dirty;
  logic [IDX_W-1:0]             pick;

  for (genvar i = 0; i < STAT_N; i++) begin : g_dirty
    assign dirty[i] = !synced[i] || shadow[i] != stat_chars[i*CHR_W +: CHR_W];
  end

  always_comb begin
    pick = '0;
    for (int i = STAT_N - 1; i >= 0; i--)
      if (dirty[i]) pick = IDX_W'(i);
  end

  assign req      = |dirty;
  assign req_data = stat_chars[int'(pick)*CHR_W +: CHR_W];
  assign req_addr = cell_addr('0, COL_W'(pick));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced <= '0;
      shadow <= '0;
    end else if (grant) begin
      shadow[pick] <= req_data;
      synced[pick] <= 1'b1;
    end
  end
endmodule

// File: rtl/txt_pw_links.sv
module txt_pw_links
  import txt_pw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [COL_W-1:0]         col,
  input  logic [NIB_W-1:0]         chr_nib,
  output logic [LINK_N*LINK_W-1:0] links
);
  for (genvar k = 0; k < LINK_N; k++) begin : g_link
    logic [LINK_W-1:0] lk;
    always_ff @(posedge clk) begin
      if (!rst_n) lk <= '0;
      else if (cap_en) begin
        if (int'(col) == 3 * k)     lk[2*NIB_W +: MAG_W] <= chr_nib[MAG_W-1:0];
        if (int'(col) == 3 * k + 1) lk[NIB_W +: NIB_W]   <= chr_nib;
        if (int'(col) == 3 * k + 2) lk[0 +: NIB_W]       <= chr_nib;
      end
    end
    assign links[k*LINK_W +: LINK_W] = lk;
  end
endmodule

// File: rtl/txt_page_writer.sv
module txt_page_writer
  import txt_pw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pkt_start,
  input  logic [MAG_W-1:0]         pkt_mag,
  input  logic [ROW_W-1:0]         pkt_row,
  input  logic [PAGE_W-1:0]        pkt_page,
  input  logic [SUB_W-1:0]         pkt_sub,
  input  logic                     chr_valid,
  input  logic [CHR_W-1:0]         chr_data,
  input  logic [MAG_W-1:0]         sel_mag,
  input  logic [PAGE_W-1:0]        sel_page,
  input  logic [SUB_W-1:0]         sel_subcode,
  input  logic                     sub_req,
  input  logic                     serial_mode,
  input  logic [STAT_N*CHR_W-1:0]  stat_chars,
  input  logic                     frame_soon,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [CHR_W-1:0]         wr_data,
  output logic [LINK_N*LINK_W-1:0] link_pages
);
  pkt_kind_e         kind_q, kind_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              hdr_full_q;
  logic              search, row_ok, found, sel_chg;
  logic              beat, char_wr, er_wr, stat_grant, stat_req;
  logic              er_busy;
  logic [ADDR_W-1:0] er_addr, stat_addr;
  logic [CHR_W-1:0]  stat_data;

  txt_pw_accept u_accept (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_mag(pkt_mag),
    .pkt_row(pkt_row), .pkt_page(pkt_page), .pkt_sub(pkt_sub),
    .sel_mag(sel_mag), .sel_page(sel_page), .sel_subcode(sel_subcode),
    .sub_req(sub_req), .serial_mode(serial_mode),
    .search(search), .row_ok(row_ok), .found(found), .sel_chg(sel_chg)
  );

  txt_pw_status u_status (
    .clk(clk), .rst_n(rst_n), .stat_chars(stat_chars), .grant(stat_grant),
    .req(stat_req), .req_addr(stat_addr), .req_data(stat_data)
  );

  txt_pw_links u_links (
    .clk(clk), .rst_n(rst_n), .cap_en(beat && kind_q == PK_LINK),
    .col(col_q), .chr_nib(chr_data[NIB_W-1:0]), .links(link_pages)
  );

  always_comb begin
    if (pkt_row == '0)                 kind_d = PK_HDR;
    else if (int'(pkt_row) < ROWS)     kind_d = row_ok ? PK_ROW : PK_NONE;
    else if (int'(pkt_row) == LINK_ROW) kind_d = row_ok ? PK_LINK : PK_NONE;
    else                               kind_d = PK_NONE;
  end

  // port arbitration: packet character, then erase, then status
  assign beat       = chr_valid && kind_q != PK_NONE;
  assign char_wr    = beat && (kind_q == PK_ROW ||
                      (kind_q == PK_HDR && (hdr_col_always(col_q) ||
                                            (hdr_full_q && hdr_col_search(col_q)))));
  assign er_wr      = er_busy && !char_wr;
  assign stat_grant = stat_req && !char_wr && !er_busy && !frame_soon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q     <= PK_NONE;
      row_q      <= '0;
      col_q      <= '0;
      hdr_full_q <= 1'b0;
    end else if (pkt_start) begin
      kind_q     <= kind_d;
      row_q      <= pkt_row;
      col_q      <= '0;
      hdr_full_q <= search && (serial_mode || pkt_mag == sel_mag);
    end else if (beat) begin
      if (int'(col_q) == COLS - 1) kind_q <= PK_NONE;
      else                         col_q  <= col_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      er_busy <= 1'b0;
      er_addr <= '0;
    end else if (found) begin
      er_busy <= 1'b1;
      er_addr <= ADDR_W'(COLS);
    end else if (er_wr) begin
      if (int'(er_addr) == CELLS - 1) er_busy <= 1'b0;
      else                            er_addr <= er_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= char_wr || er_wr || stat_grant;
      wr_addr <= char_wr ? cell_addr(row_q, col_q) : (er_wr ? er_addr : stat_addr);
      wr_data <= char_wr ? chr_data : (er_wr ? SPACE : stat_data);
    end
  end
endmodule

// File: rtl/txt_pw_checker.sv
module txt_pw_checker
  import txt_pw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_soon,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CHR_W-1:0]  wr_data,
  input logic              char_wr,
  input logic              er_wr,
  input logic              stat_grant,
  input logic              found,
  input logic              search,
  input logic              sel_chg
);
  AST_ADDR_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < CELLS); // R1

  AST_CHAR_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    char_wr |=> wr_en); // R1

  AST_STATUS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) < STAT_N) |-> !$past(frame_soon)); // R10

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({char_wr, er_wr, stat_grant})); // R10

  AST_FOUND_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !search); // R5

  AST_ERASE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    er_wr |=> (wr_en && wr_data == SPACE)); // R5

  AST_SEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> search); // R12
endmodule

bind txt_page_writer txt_pw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_soon(frame_soon), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .char_wr(char_wr), .er_wr(er_wr),
  .stat_grant(stat_grant), .found(found), .search(search), .sel_chg(sel_chg)
);

// File: tb/txt_page_writer_tb.sv
module txt_page_writer_tb;
  localparam int NCELL = 1000;
  localparam int NVEC  = 11;
  // {mag[26:24], row[23:19], page[18:11], base[10:4], wlo, whi, wrow, erase}
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd2, 5'd0, 8'h50, 7'h41, 4'b0100},  // R2 R3 other magazine in search
    {3'd1, 5'd0, 8'h22, 7'h45, 4'b1100},  // R3 selected magazine in search
    {3'd1, 5'd5, 8'h00, 7'h30, 4'b0000},  // R6 no matching header yet
    {3'd1, 5'd0, 8'h23, 7'h50, 4'b1101},  // R5 match, erase
    {3'd1, 5'd5, 8'h00, 7'h31, 4'b0010},  // R1 R6 accepted row
    {3'd3, 5'd6, 8'h00, 7'h32, 4'b0000},  // R6 wrong magazine
    {3'd2, 5'd0, 8'h50, 7'h60, 4'b0100},  // R2 R3 out of search
    {3'd1, 5'd0, 8'h24, 7'h48, 4'b0100},  // R3 R6 non-matching header
    {3'd1, 5'd7, 8'h00, 7'h33, 4'b0000},  // R6 acceptance withdrawn
    {3'd1, 5'd0, 8'h23, 7'h52, 4'b0100},  // R3 match outside search
    {3'd1, 5'd7, 8'h00, 7'h34, 4'b0010}   // R1 R6 accepted again
  };

  logic        clk = 0, rst_n = 0;
  logic        pkt_start = 0, chr_valid = 0, sub_req = 0, serial_mode = 0, frame_soon = 0;
  logic [2:0]  pkt_mag = 0, sel_mag = 3'd1;
  logic [4:0]  pkt_row = 0;
  logic [7:0]  pkt_page = 0, sel_page = 8'h23;
  logic [12:0] pkt_sub = 0, sel_subcode = 0;
  logic [6:0]  chr_data = 0;
  logic [55:0] stat_chars;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [6:0]  wr_data;
  logic [54:0] link_pages;

  logic [6:0] ram [NCELL];
  logic [6:0] exp_ram [NCELL];
  int checks = 0, fails = 0;
  bit done = 0;

  txt_page_writer u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_mag(pkt_mag),
    .pkt_row(pkt_row), .pkt_page(pkt_page), .pkt_sub(pkt_sub),
    .chr_valid(chr_valid), .chr_data(chr_data), .sel_mag(sel_mag),
    .sel_page(sel_page), .sel_subcode(sel_subcode), .sub_req(sub_req),
    .serial_mode(serial_mode), .stat_chars(stat_chars), .frame_soon(frame_soon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .link_pages(link_pages)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (wr_en && int'(wr_addr) < NCELL) ram[wr_addr] = wr_data;

  function automatic logic [6:0] pkt_char(input logic [4:0] row, input logic [6:0] base,
                                          input int c);
    if (row == 5'd27 && c < 15) begin
      if (c % 3 == 0)      return 7'(c / 3 + 1);
      else if (c % 3 == 1) return 7'(c / 3 + 2);
      else                 return 7'(9 - c / 3);
    end
    return 7'((int'(base) + c) & 'h7f);
  endfunction

  task automatic check_ram(input string tag);
    int bad = 0, first = -1;
    for (int a = 0; a < NCELL; a++)
      if (ram[a] !== exp_ram[a]) begin bad++; if (first < 0) first = a; end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: cell %0d actual %h expected %h (%0d cells differ)",
               tag, first, ram[first], exp_ram[first], bad);
    end
  endtask

  task automatic send_pkt(input logic [2:0] mag, input logic [4:0] row, input logic [7:0] page,
                          input logic [12:0] sub, input logic [6:0] base,
                          input logic wlo, input logic whi, input logic wrow,
                          input logic er, input string tag);
    @(negedge clk);
    pkt_start = 1; pkt_mag = mag; pkt_row = row; pkt_page = page; pkt_sub = sub;
    @(negedge clk);
    pkt_start = 0;
    for (int c = 0; c < 40; c++) begin
      chr_valid = 1; chr_data = pkt_char(row, base, c);
      @(negedge clk);
    end
    chr_valid = 0;
    if (er) for (int a = 40; a < NCELL; a++) exp_ram[a] = 7'h20;
    for (int c = 0; c < 40; c++) begin
      if (row == 5'd0) begin
        if ((c >= 32 && whi) || (c >= 8 && c < 32 && wlo)) exp_ram[c] = pkt_char(row, base, c);
      end else if (wrow) exp_ram[int'(row) * 40 + c] = pkt_char(row, base, c);
    end
    repeat (1000) @(negedge clk);
    check_ram(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [54:0] exp_links;
    for (int a = 0; a < NCELL; a++) begin ram[a] = 7'h00; exp_ram[a] = 7'h00; end
    for (int i = 0; i < 8; i++) stat_chars[i*7 +: 7] = 7'(8'h41 + i);
    repeat (3) @(negedge clk);
    // R13 reset state
    checks++;
    if (wr_en !== 1'b0) begin fails++; $display("FAIL R13: wr_en actual %b expected 0", wr_en); end
    checks++;
    if (link_pages !== '0) begin fails++; $display("FAIL R13: link_pages actual %h expected 0", link_pages); end
    rst_n = 1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 8; i++) exp_ram[i] = 7'(8'h41 + i);
    check_ram("R9 initial status copy");

    for (int v = 0; v < NVEC; v++)
      send_pkt(VEC[v][26:24], VEC[v][23:19], VEC[v][18:11], 13'd0, VEC[v][10:4],
               VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], $sformatf("R1-R6 vector %0d", v));

    // R12 new selection drops acceptance and re-enters search
    sel_page = 8'h25;
    repeat (3) @(negedge clk);
    send_pkt(3'd1, 5'd10, 8'h00, 13'd0, 7'h35, 0, 0, 0, 0, "R12 row after reselect");
    send_pkt(3'd1, 5'd0, 8'h30, 13'd0, 7'h70, 1, 1, 0, 0, "R12 header in search again");

    // R4 R7 serial transmission
    serial_mode = 1; sel_mag = 3'd4; sel_page = 8'h10;
    repeat (3) @(negedge clk);
    send_pkt(3'd2, 5'd0, 8'h77, 13'd0, 7'h40, 1, 1, 0, 0, "R4 other magazine header");
    send_pkt(3'd4, 5'd0, 8'h10, 13'd0, 7'h44, 1, 1, 0, 1, "R5 R7 matching header");
    send_pkt(3'd4, 5'd3, 8'h00, 13'd0, 7'h36, 0, 0, 1, 0, "R7 row accepted");
    send_pkt(3'd6, 5'd4, 8'h00, 13'd0, 7'h37, 0, 0, 1, 0, "R7 row of any magazine");
    send_pkt(3'd2, 5'd0, 8'h77, 13'd0, 7'h46, 0, 1, 0, 0, "R2 R7 foreign header");
    send_pkt(3'd4, 5'd9, 8'h00, 13'd0, 7'h38, 0, 0, 0, 0, "R7 row after foreign header");

    // R8 subcode matching
    sub_req = 1; sel_subcode = 13'd5;
    repeat (3) @(negedge clk);
    send_pkt(3'd4, 5'd0, 8'h10, 13'd6, 7'h49, 1, 1, 0, 0, "R8 wrong subcode header");
    send_pkt(3'd4, 5'd2, 8'h00, 13'd0, 7'h39, 0, 0, 0, 0, "R8 row rejected");
    send_pkt(3'd4, 5'd0, 8'h10, 13'd5, 7'h4a, 1, 1, 0, 1, "R8 right subcode header");
    send_pkt(3'd4, 5'd2, 8'h00, 13'd0, 7'h3a, 0, 0, 1, 0, "R8 row accepted");

    // R11 editorial links
    send_pkt(3'd4, 5'd27, 8'h00, 13'd0, 7'h20, 0, 0, 0, 0, "R11 link packet leaves screen");
    for (int k = 0; k < 5; k++) exp_links[k*11 +: 11] = {3'(k + 1), 4'(k + 2), 4'(9 - k)};
    checks++;
    if (link_pages !== exp_links) begin
      fails++;
      $display("FAIL R11: link_pages actual %h expected %h", link_pages, exp_links);
    end

    // R10 status hold-off
    frame_soon = 1;
    @(negedge clk);
    stat_chars[3*7 +: 7] = 7'h5a;
    repeat (30) @(negedge clk);
    check_ram("R10 status held while frame_soon");
    frame_soon = 0;
    repeat (5) @(negedge clk);
    exp_ram[3] = 7'h5a;
    check_ram("R9 R10 status written after release");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule